// File: doc/BRIEF.md
# Synchronous Burst Latency and Address Sequencer

This block produces the timing skeleton of a synchronous burst read from a memory array. When an address-valid strobe is sampled high, it captures the start word address. It then holds a wait indication for a number of clocks before the first data word is valid. That number depends on three things: the parity of the start address, whether the first word pair straddles a 64-word block, and the selected clock-frequency class.

Once the wait is over, a data-valid flag is raised every clock and the array address steps by one word per clock. In the fixed-length modes (8, 16 or 32 words), the address wraps inside its aligned window and never leaves the enclosing 64-word block. In continuous mode it keeps counting upward. A fresh strobe at any time abandons the current burst and starts over from the new address.

Top module: `burst_seq`

## Requirements
- R1: After reset, `waitOut` and `dataValid` are 0 and `arrayAddr` is 0.
- R2: Take the rising edge that samples `addrValid` high as edge 0. `dataValid` first reads 1 after edge N. With `fastClass`=0, an even start address and no block crossing, N is 4.
- R3: With `fastClass`=0, an odd start address and no block crossing, N is 5.
- R4: With `fastClass`=1, each latency is one clock longer: 5 for an even start and 6 for an odd start.
- R5: A block crossing exists when the low six start-address bits are all ones (the last word of a 64-word block). The latency is then 7 with `fastClass`=0 and 8 with `fastClass`=1.
- R6: `waitOut` is 1 from edge 0 until `dataValid` rises, and is never 1 together with `dataValid`.
- R7: `arrayAddr` equals the start address from edge 0 through the first data cycle. In each later cycle of the burst it moves to the next word, and `dataValid` stays 1 until a new strobe.
- R8: For `burstLen` 1, 2 and 3 (8, 16 and 32 words), only the low 3, 4 or 5 address bits count, wrapping to zero inside the aligned window. All higher bits stay fixed.
- R9: For `burstLen` 0 (continuous), the full address increments by one each data cycle, including across a 64-word boundary.
- R10: A strobe during a burst or during the wait restarts the sequence. After that edge, `waitOut`=1, `dataValid`=0, `arrayAddr` holds the new start, and the latency is recounted for the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Start strobe, sampled on the rising edge |
| startAddr | input | ADDR_W | Word address captured with the strobe |
| burstLen | input | 2 | 0 continuous, 1 eight, 2 sixteen, 3 thirty-two words |
| fastClass | input | 1 | 1 selects the higher frequency class |
| arrayAddr | output | ADDR_W | Current array word address |
| dataValid | output | 1 | High in each cycle that carries a valid word |
| waitOut | output | 1 | High while the initial latency is being counted |

## Verification
The address assertions compare each step against the burst mode present in the same cycle. They therefore assume that `burstLen` and `fastClass` change only in the cycle that carries a strobe. The stimulus respects this by setting both inputs together with `addrValid` and holding them until the next strobe. Strobes are single-cycle pulses, except where a restart is the point of the scenario. Start addresses are chosen to cover even, odd and block-crossing cases, and window edges for each wrap size.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    LEN_CONT = 2'd0,
    LEN_8    = 2'd1,
    LEN_16   = 2'd2,
    LEN_32   = 2'd3
  } burstLen_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqCmd_t;

endpackage

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_W  = 6,
  parameter int BASE_LAT = 4,
  parameter int LAT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  burstLen_e         lenSel,
  input  logic              fastClass,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [LAT_W-1:0]  firstLatency
);

  localparam logic [ADDR_W-1:0] MASK_8  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] MASK_16 = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] MASK_32 = ADDR_W'(31);
  localparam logic [ADDR_W-1:0] MASK_ALL = '1;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] wrapMask;
  logic [ADDR_W-1:0] nextAddr;
  logic              startOdd;
  logic              crossBlk;

  always_comb begin
    case (lenSel)
      LEN_8:   wrapMask = MASK_8;
      LEN_16:  wrapMask = MASK_16;
      LEN_32:  wrapMask = MASK_32;
      default: wrapMask = MASK_ALL;
    endcase
  end

  // only bits under the mask advance; the rest stay put
  assign nextAddr = (addrQ & ~wrapMask) | ((addrQ + ADDR_W'(1)) & wrapMask);

  // first fetched pair spans two blocks when start is the block's last word
  assign startOdd = startAddr[0];
  assign crossBlk = &startAddr[BLOCK_W-1:0];

  assign firstLatency = LAT_W'(BASE_LAT) + LAT_W'(startOdd) + LAT_W'(fastClass)
                      + (crossBlk ? LAT_W'(2) : LAT_W'(0));

  always_ff @(posedge clk) begin
    if (!rstN)         addrQ <= '0;
    else if (cmd.load) addrQ <= startAddr;
    else if (cmd.step) addrQ <= nextAddr;
  end

  assign arrayAddr = addrQ;

  a_r7_load: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> arrayAddr == $past(startAddr));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load && !cmd.step |=> $stable(arrayAddr));

  a_r9_cont_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !cmd.load && lenSel == LEN_CONT
      |=> arrayAddr == $past(arrayAddr) + ADDR_W'(1));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !cmd.load && lenSel != LEN_CONT
      |=> ((arrayAddr ^ $past(arrayAddr)) & ~$past(wrapMask)) == '0);

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrValid,
  input  logic [LAT_W-1:0] firstLatency,
  output seqCmd_t          cmd,
  output logic             waitOut,
  output logic             dataValid
);

  seqState_e        stateQ;
  logic [LAT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else if (addrValid) begin
      stateQ <= ST_WAIT;
      cntQ   <= firstLatency - LAT_W'(1);
    end else begin
      case (stateQ)
        ST_WAIT: begin
          if (cntQ == '0) stateQ <= ST_DATA;
          else            cntQ   <= cntQ - LAT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign waitOut   = (stateQ == ST_WAIT);
  assign dataValid = (stateQ == ST_DATA);
  assign cmd.load  = addrValid;
  assign cmd.step  = (stateQ == ST_DATA) && !addrValid;

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(waitOut && dataValid));

  a_r10_reload: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> waitOut && !dataValid);

  a_r2_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    waitOut && cntQ != '0 && !addrValid |=> waitOut);

  a_r2_wait_exit: assert property (@(posedge clk) disable iff (!rstN)
    waitOut && cntQ == '0 && !addrValid |=> dataValid);

  a_r7_valid_stays: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && !addrValid |=> dataValid);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_W  = 6,
  parameter int BASE_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        burstLen,
  input  logic              fastClass,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              dataValid,
  output logic              waitOut
);

  // worst case adds odd, fast class and crossing to the base
  localparam int MAX_LAT = BASE_LAT + 4;
  localparam int LAT_W   = $clog2(MAX_LAT + 1) + 1;

  seqCmd_t          cmd;
  logic [LAT_W-1:0] firstLatency;

  burst_seq_addr #(
    .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .BASE_LAT(BASE_LAT), .LAT_W(LAT_W)
  ) i_addr (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr),
    .lenSel(burstLen_e'(burstLen)), .fastClass(fastClass),
    .arrayAddr(arrayAddr), .firstLatency(firstLatency)
  );

  burst_seq_ctrl #(.LAT_W(LAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .firstLatency(firstLatency),
    .cmd(cmd), .waitOut(waitOut), .dataValid(dataValid)
  );

endmodule

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrValid;
  logic [15:0] startAddr;
  logic [1:0]  burstLen;
  logic        fastClass;
  logic [15:0] arrayAddr;
  logic        dataValid;
  logic        waitOut;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_seq i_burst_seq (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .startAddr(startAddr),
    .burstLen(burstLen), .fastClass(fastClass), .arrayAddr(arrayAddr),
    .dataValid(dataValid), .waitOut(waitOut)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  function automatic logic [15:0] expNext(input logic [15:0] a, input logic [1:0] l);
    case (l)
      2'd1:    return {a[15:3], a[2:0] + 3'd1};
      2'd2:    return {a[15:4], a[3:0] + 4'd1};
      2'd3:    return {a[15:5], a[4:0] + 5'd1};
      default: return a + 16'd1;
    endcase
  endfunction

  // strobe, check the latency, then follow nWords data cycles
  task automatic runBurst(input logic [15:0] start, input logic [1:0] len, input bit fast,
                          input int expLat, input int nWords, input string req);
    int lat = 0;
    bit waitGap = 1'b0;
    logic [15:0] expA = start;
    @(negedge clk);
    addrValid = 1'b1; startAddr = start; burstLen = len; fastClass = fast;
    @(negedge clk);
    addrValid = 1'b0;
    check(waitOut && !dataValid, "R6/R10 wait after strobe", {waitOut, dataValid}, 2'b10);
    check(arrayAddr == start, "R7/R10 start loaded", arrayAddr, start);
    while (!dataValid && lat < 20) begin
      @(negedge clk);
      lat++;
      if (!dataValid && !waitOut) waitGap = 1'b1;
      if (dataValid && waitOut) waitGap = 1'b1;
    end
    check(lat == expLat, req, lat, expLat);
    check(!waitGap, "R6 wait spans latency", waitGap, 0);
    for (int w = 0; w < nWords; w++) begin
      check(dataValid && arrayAddr == expA, (len == 0) ? "R9 cont addr" : "R8/R7 wrap addr",
            arrayAddr, expA);
      if (w < nWords - 1) begin
        @(negedge clk);
        expA = expNext(expA, len);
      end
    end
  endtask

  task automatic testReset;
    rstN = 1'b0; addrValid = 1'b0; startAddr = 16'h1234; burstLen = 2'd0; fastClass = 1'b0;
    repeat (3) @(negedge clk);
    check(!waitOut && !dataValid && arrayAddr == 16'h0, "R1 reset state",
          {arrayAddr, waitOut, dataValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!waitOut && !dataValid, "R1 idle after reset", {waitOut, dataValid}, 0);
  endtask

  task automatic testLatencies;
    runBurst(16'h0010, 2'd1, 1'b0, 4, 2, "R2 slow even latency");
    runBurst(16'h0011, 2'd1, 1'b0, 5, 2, "R3 slow odd latency");
    runBurst(16'h0020, 2'd2, 1'b1, 5, 2, "R4 fast even latency");
    runBurst(16'h0021, 2'd2, 1'b1, 6, 2, "R4 fast odd latency");
    runBurst(16'h003F, 2'd0, 1'b0, 7, 3, "R5 slow crossing latency");
    runBurst(16'h013F, 2'd3, 1'b1, 8, 3, "R5 fast crossing latency");
  endtask

  task automatic testWraps;
    runBurst(16'h0105, 2'd1, 1'b0, 5, 12, "R3 wrap8 latency");
    runBurst(16'h4A3C, 2'd2, 1'b0, 4, 20, "R2 wrap16 latency");
    runBurst(16'h2A1D, 2'd3, 1'b1, 6, 40, "R4 wrap32 latency");
  endtask

  task automatic testContinuous;
    runBurst(16'h003D, 2'd0, 1'b0, 5, 8, "R3 cont latency");
    runBurst(16'hFFFC, 2'd0, 1'b1, 5, 6, "R4 cont top latency");
  endtask

  task automatic testAbort;
    // restart in the middle of data
    runBurst(16'h0200, 2'd1, 1'b0, 4, 3, "R2 pre-abort latency");
    runBurst(16'h0333, 2'd2, 1'b1, 6, 4, "R10 restart in data latency");
    // restart during the wait
    @(negedge clk);
    addrValid = 1'b1; startAddr = 16'h0500; burstLen = 2'd1; fastClass = 1'b0;
    @(negedge clk);
    addrValid = 1'b0;
    @(negedge clk);
    check(waitOut && !dataValid, "R10 still waiting", {waitOut, dataValid}, 2'b10);
    runBurst(16'h007F, 2'd1, 1'b0, 7, 9, "R10 restart in wait latency");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    testReset();
    testLatencies();
    testWraps();
    testContinuous();
    testAbort();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule